// File: doc/BRIEF.md
# Parallel Camera Pixel Capture

This block takes the byte stream of a parallel 8-bit image sensor and turns it into 16-bit RGB565 pixel words. It runs entirely on the sensor's pixel clock. Its inputs are a vertical sync, a row-valid strobe and the data bus. After reset, or after an arm request, it never joins a frame that is already under way. It first lets any frame in progress run out. It then waits for the vertical sync to reach its active level. The level that counts as active is set by a configuration input.

Inside a frame, every rising pixel-clock edge with the row strobe high delivers one byte. Two such bytes make one pixel. Each completed pixel is presented for one cycle with a valid strobe and a linear address that counts from zero at the start of the frame. A start-of-frame marker goes with the first pixel. An end-of-line marker goes with the last column of each row. A one-cycle done pulse signals that the frame has ended. The downstream side, such as a frame store or a stream interface, simply registers whatever it sees while the valid strobe is high.

Top module: `pixel_capture`

## Requirements
- R1: While reset is low, and in the cycle after it, `pix_valid_o`, `sof_o`, `eol_o` and `frame_done_o` are all 0.
- R2: A frame whose vertical sync is already active when reset is released produces no pixels and no done pulse. Capture starts with the next frame whose vertical sync becomes active.
- R3: Bytes are taken on rising clock edges. The first byte of a pair goes to `pix_data_o[15:8]` and the second to `pix_data_o[7:0]`. `pix_valid_o` is high for exactly the one cycle after the edge that took the second byte.
- R4: A byte is taken only when `href_i` is 1 and vertical sync is active at that edge. Data presented while `href_i` is 0 produces no pixel.
- R5: The byte phase is cleared whenever `href_i` is low. A row with an odd byte count drops its last byte, and the next row pairs its bytes from its own first byte.
- R6: `pix_addr_o` is 0 for the first pixel of each captured frame and rises by one for each following pixel. It wraps to 0 after H_PIX*V_LINES-1.
- R7: `eol_o` is high together with `pix_valid_o` on the pixel in column H_PIX-1. The column count restarts at 0 at each row end.
- R8: `sof_o` is high together with `pix_valid_o` on the first pixel of a captured frame, and on no other pixel.
- R9: When vertical sync leaves its active level during a captured frame, `frame_done_o` pulses for one cycle. Row strobes outside the active vertical sync produce no pixels.
- R10: With `vs_pol_i` = 1, vertical sync is active when high. With `vs_pol_i` = 0, it is active when low.
- R11: A one-cycle `arm_i` pulse abandons the current frame without a done pulse. The block then waits for the active vertical sync to end before it captures the next frame, whose addresses again start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock; all logic uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | One-cycle request to resynchronise to a fresh frame |
| vs_pol_i | input | 1 | Vertical sync active level (1 = high, 0 = low) |
| vsync_i | input | 1 | Vertical sync from the sensor |
| href_i | input | 1 | Row-valid strobe from the sensor |
| data_i | input | 8 | Sensor data byte |
| pix_valid_o | output | 1 | One-cycle strobe for a completed pixel |
| pix_data_o | output | 16 | RGB565 pixel word |
| pix_addr_o | output | ADDR_W | Linear pixel address within the frame |
| sof_o | output | 1 | First pixel of a frame |
| eol_o | output | 1 | Last column of a row |
| frame_done_o | output | 1 | One-cycle pulse when a captured frame ends |

## Verification
The assertions assume that vertical sync, the row strobe and the data settle between rising edges. They also assume that `vs_pol_i` changes only while no frame is being captured, and that a frame holds its active vertical sync for at least one edge before its first row. The bench changes every input on the falling edge. It always leaves idle cycles between a vertical sync edge and the first or last row. It changes the polarity only between frames, followed by an arm pulse. The bench uses a 4-by-3 frame, so that wrapping, end-of-line and full-frame behaviour appear within a few dozen cycles.

// File: rtl/cap_pkg.sv
// Shared types for the pixel capture block.
package cap_pkg;
    // Frame synchroniser states: drain current frame, await new one, capture.
    typedef enum logic [1:0] {
        ST_DRAIN = 2'd0,
        ST_AWAIT = 2'd1,
        ST_GRAB  = 2'd2
    } sync_st_t;
endpackage

// File: rtl/cap_frame_sync.sv
// Frame synchroniser.
// Tracks vertical sync so that capture starts only at a clean frame boundary.
// After reset or arm it drains any active frame, awaits the next active level,
// then qualifies row bytes until the frame ends.
// Assumes vsync and href are stable around the rising clock edge.
module cap_frame_sync
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic vs_pol_i,
    input  logic vsync_i,
    input  logic href_i,
    output logic capture_o,
    output logic frame_start_o,
    output logic frame_end_o,
    output logic in_frame_o
);
    sync_st_t st_q;
    sync_st_t st_d;
    logic     vs_act;

    // Active vertical sync, honouring the configured polarity.
    assign vs_act = (vsync_i == vs_pol_i);

    // Next-state selection for the synchroniser.
    always_comb begin
        st_d = st_q;
        if (arm_i) begin
            st_d = ST_DRAIN;
        end else begin
            case (st_q)
                ST_DRAIN: if (!vs_act) st_d = ST_AWAIT;
                ST_AWAIT: if (vs_act)  st_d = ST_GRAB;
                ST_GRAB:  if (!vs_act) st_d = ST_AWAIT;
                default:               st_d = ST_DRAIN;
            endcase
        end
    end

    // State register; reset lands in the drain state so no frame is joined late.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_DRAIN;
        else        st_q <= st_d;
    end

    assign in_frame_o    = (st_q == ST_GRAB);
    assign frame_start_o = (st_q == ST_AWAIT) && vs_act && !arm_i;
    assign frame_end_o   = in_frame_o && !vs_act && !arm_i;
    assign capture_o     = in_frame_o && vs_act && href_i && !arm_i;
endmodule

// File: rtl/cap_byte_pack.sv
// Byte pairer.
// Joins two consecutive qualified bytes into one word, first byte in the upper
// half. The phase clears whenever capture drops, so each row pairs from its
// own first byte.
// Assumes capture_i is already gated by row and frame validity.
module cap_byte_pack #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              pix_done_o,
    output logic [WORD_W-1:0] word_o
);
    logic              phase_q;
    logic [BYTE_W-1:0] hi_q;

    // Phase toggles on each qualified byte and clears between rows.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= 1'b0;
        else if (!capture_i) phase_q <= 1'b0;
        else                 phase_q <= ~phase_q;
    end

    // Hold the first byte of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hi_q <= '0;
        else if (capture_i && !phase_q) hi_q <= data_i;
    end

    assign pix_done_o = capture_i && phase_q;
    assign word_o     = {hi_q, data_i};
endmodule

// File: rtl/cap_pix_track.sv
// Pixel tracker and output register.
// Counts the address and column of each finished pixel and registers the word
// together with its start-of-frame and end-of-line markers and the done pulse.
// Assumes frame_start_i and pix_done_i are never high in the same cycle.
module cap_pix_track #(
    parameter int H_PIX   = 640,
    parameter int V_LINES = 480,
    parameter int WORD_W  = 16,
    localparam int PIX_N  = H_PIX * V_LINES,
    localparam int ADDR_W = (PIX_N > 1) ? $clog2(PIX_N) : 1,
    localparam int COL_W  = (H_PIX > 1) ? $clog2(H_PIX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              frame_end_i,
    input  logic              capture_i,
    input  logic              pix_done_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] data_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sof_o,
    output logic              eol_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(PIX_N - 1);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(H_PIX - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [COL_W-1:0]  col_q;
    logic              first_q;
    logic              cap_q;
    logic              row_end;

    assign row_end = cap_q && !capture_i;

    // Remember last cycle's capture to find the end of each row.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= capture_i;
    end

    // Address, column and first-pixel bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            col_q   <= '0;
            first_q <= 1'b0;
        end else if (frame_start_i) begin
            addr_q  <= '0;
            col_q   <= '0;
            first_q <= 1'b1;
        end else if (pix_done_i) begin
            addr_q  <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
            col_q   <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
            first_q <= 1'b0;
        end else if (row_end) begin
            col_q   <= '0;
        end
    end

    // One-cycle strobes presented with each pixel or frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            sof_o   <= 1'b0;
            eol_o   <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            valid_o <= pix_done_i;
            sof_o   <= pix_done_i && first_q;
            eol_o   <= pix_done_i && (col_q == COL_LAST);
            done_o  <= frame_end_i;
        end
    end

    // Pixel word and address hold until the next pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            addr_o <= '0;
        end else if (pix_done_i) begin
            data_o <= word_i;
            addr_o <= addr_q;
        end
    end
endmodule

// File: rtl/pixel_capture.sv
// Parallel camera pixel capture, top level.
// Runs in the sensor pixel clock domain. It synchronises to a whole frame,
// pairs bytes into RGB565 words and tags each word with its address and markers.
// Assumes inputs change away from the rising edge and vs_pol_i is static during capture.
module pixel_capture #(
    parameter int H_PIX   = 640,
    parameter int V_LINES = 480,
    parameter int BYTE_W  = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int PIX_N  = H_PIX * V_LINES,
    localparam int ADDR_W = (PIX_N > 1) ? $clog2(PIX_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              vs_pol_i,
    input  logic              vsync_i,
    input  logic              href_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              pix_valid_o,
    output logic [WORD_W-1:0] pix_data_o,
    output logic [ADDR_W-1:0] pix_addr_o,
    output logic              sof_o,
    output logic              eol_o,
    output logic              frame_done_o
);
    logic              capture;
    logic              frame_start;
    logic              frame_end;
    logic              in_frame;
    logic              pix_done;
    logic [WORD_W-1:0] word;

    cap_frame_sync u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm_i),
        .vs_pol_i     (vs_pol_i),
        .vsync_i      (vsync_i),
        .href_i       (href_i),
        .capture_o    (capture),
        .frame_start_o(frame_start),
        .frame_end_o  (frame_end),
        .in_frame_o   (in_frame)
    );

    cap_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .data_i    (data_i),
        .pix_done_o(pix_done),
        .word_o    (word)
    );

    cap_pix_track #(.H_PIX(H_PIX), .V_LINES(V_LINES), .WORD_W(WORD_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start),
        .frame_end_i  (frame_end),
        .capture_i    (capture),
        .pix_done_i   (pix_done),
        .word_i       (word),
        .valid_o      (pix_valid_o),
        .data_o       (pix_data_o),
        .addr_o       (pix_addr_o),
        .sof_o        (sof_o),
        .eol_o        (eol_o),
        .done_o       (frame_done_o)
    );
endmodule

// File: rtl/cap_checker.sv
// Assertion checker for pixel_capture, attached with bind.
// Assumes inputs settle between rising edges.
module cap_checker #(
    parameter int PIX_N  = 4,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              href_i,
    input logic              in_frame,
    input logic              pix_valid_o,
    input logic [ADDR_W-1:0] pix_addr_o,
    input logic              sof_o,
    input logic              eol_o,
    input logic              frame_done_o
);
    logic [ADDR_W-1:0] last_addr;
    logic              seen;
    logic [ADDR_W-1:0] next_addr;

    assign next_addr = (last_addr == ADDR_W'(PIX_N - 1)) ? '0 : last_addr + 1'b1;

    // Track the previous pixel address for the step check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            seen      <= 1'b0;
        end else if (pix_valid_o) begin
            last_addr <= pix_addr_o;
            seen      <= 1'b1;
        end
    end

    p_quiet_reset_r1: assert property (@(posedge clk) !rst_n |=> !pix_valid_o && !frame_done_o);
    p_idle_no_pix_r2: assert property (@(posedge clk) disable iff (!rst_n) !in_frame |=> !pix_valid_o);
    p_row_gate_r4:    assert property (@(posedge clk) disable iff (!rst_n) !href_i |=> !pix_valid_o);
    p_addr_step_r6:   assert property (@(posedge clk) disable iff (!rst_n)
                                       pix_valid_o && !sof_o && seen |-> pix_addr_o == next_addr);
    p_eol_valid_r7:   assert property (@(posedge clk) disable iff (!rst_n) eol_o |-> pix_valid_o);
    p_sof_zero_r8:    assert property (@(posedge clk) disable iff (!rst_n) sof_o |-> pix_valid_o && pix_addr_o == '0);
    p_done_pulse_r9:  assert property (@(posedge clk) disable iff (!rst_n) frame_done_o |=> !frame_done_o);
    p_addr_range_r6:  assert property (@(posedge clk) disable iff (!rst_n) pix_valid_o |-> 32'(pix_addr_o) < PIX_N);
endmodule

bind pixel_capture cap_checker #(.PIX_N(PIX_N), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .href_i      (href_i),
    .in_frame    (in_frame),
    .pix_valid_o (pix_valid_o),
    .pix_addr_o  (pix_addr_o),
    .sof_o       (sof_o),
    .eol_o       (eol_o),
    .frame_done_o(frame_done_o)
);

// File: tb/sim_pixel_capture.sv
module sim_pixel_capture;
    localparam int H = 4;
    localparam int V = 3;
    localparam int AW = $clog2(H * V);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic          pol = 1'b1;
    logic          vsync = 1'b0;
    logic          href = 1'b0;
    logic [7:0]    data = 8'h00;
    logic          valid, sof, eol, done;
    logic [15:0]   pdata;
    logic [AW-1:0] paddr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] m_data [64];
    int          m_addr [64];
    bit          m_sof  [64];
    bit          m_eol  [64];
    int          m_n = 0;
    int          m_done = 0;

    always #10 clk = ~clk;

    pixel_capture #(.H_PIX(H), .V_LINES(V)) u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .vs_pol_i(pol), .vsync_i(vsync),
        .href_i(href), .data_i(data), .pix_valid_o(valid), .pix_data_o(pdata),
        .pix_addr_o(paddr), .sof_o(sof), .eol_o(eol), .frame_done_o(done)
    );

    // Monitor: sample outputs 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (valid && m_n < 64) begin
            m_data[m_n] = pdata;
            m_addr[m_n] = int'(paddr);
            m_sof[m_n]  = sof;
            m_eol[m_n]  = eol;
            m_n++;
        end
        if (done) m_done++;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(logic [7:0] seed, int r, int k);
        return seed + 8'(r * 16 + k);
    endfunction

    task automatic clear_mon();
        m_n = 0;
        m_done = 0;
    endtask

    task automatic vs_set(bit act);
        vsync = act ? pol : ~pol;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_row(int r, int nbytes, logic [7:0] seed);
        for (int k = 0; k < nbytes; k++) begin
            @(negedge clk);
            href = 1'b1;
            data = bval(seed, r, k);
        end
        @(negedge clk);
        href = 1'b0;
        data = 8'hEE;
        idle(2);
    endtask

    task automatic run_frame(int rows, int bpr, logic [7:0] seed);
        @(negedge clk);
        vs_set(1);
        idle(2);
        for (int r = 0; r < rows; r++) send_row(r, bpr, seed);
        vs_set(0);
        idle(4);
    endtask

    task automatic check_frame(int rows, int bpr, logic [7:0] seed, string tag);
        int ppr = bpr / 2;
        chk(m_n == rows * ppr, {tag, " R3 pixel count"}, m_n, rows * ppr);
        chk(m_done == 1, {tag, " R9 done pulses"}, m_done, 1);
        for (int r = 0; r < rows; r++) begin
            for (int p = 0; p < ppr; p++) begin
                int i = r * ppr + p;
                logic [15:0] exp = {bval(seed, r, 2 * p), bval(seed, r, 2 * p + 1)};
                if (i < m_n) begin
                    chk(m_data[i] == exp, {tag, " R3 word"}, m_data[i], exp);
                    chk(m_addr[i] == i, {tag, " R6 addr"}, m_addr[i], i);
                    chk(m_sof[i] == (i == 0), {tag, " R8 sof"}, m_sof[i], i == 0);
                    chk(m_eol[i] == (p == H - 1), {tag, " R7 eol"}, m_eol[i], p == H - 1);
                end
            end
        end
    endtask

    // R1, R2: reset quiet, mid-frame entry skipped.
    task automatic t_reset_midframe();
        rst_n = 1'b0;
        vs_set(1);
        idle(3);
        chk(!valid && !sof && !eol && !done, "R1 outputs in reset", {valid, sof, eol, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!valid && !done, "R1 outputs after reset", {valid, done}, 0);
        clear_mon();
        send_row(0, 8, 8'h20);
        send_row(1, 8, 8'h20);
        vs_set(0);
        idle(4);
        chk(m_n == 0, "R2 no pixels from joined frame", m_n, 0);
        chk(m_done == 0, "R2 no done from joined frame", m_done, 0);
        clear_mon();
        run_frame(3, 8, 8'h10);
        check_frame(3, 8, 8'h10, "first frame");
    endtask

    // R3, R6, R7, R8, R9: full frame of 12 pixels.
    task automatic t_basic();
        clear_mon();
        run_frame(3, 8, 8'h40);
        check_frame(3, 8, 8'h40, "basic");
    endtask

    // R5: odd byte count in a row must not misalign the next row.
    task automatic t_odd_row();
        clear_mon();
        @(negedge clk);
        vs_set(1);
        idle(2);
        send_row(0, 7, 8'h80);
        send_row(1, 8, 8'h80);
        vs_set(0);
        idle(4);
        chk(m_n == 7, "R5 pixel count", m_n, 7);
        if (m_n == 7) begin
            chk(m_data[2] == {bval(8'h80, 0, 4), bval(8'h80, 0, 5)}, "R5 last pixel row0", m_data[2], 0);
            chk(m_data[3] == {bval(8'h80, 1, 0), bval(8'h80, 1, 1)}, "R5 row1 realigned",
                m_data[3], {bval(8'h80, 1, 0), bval(8'h80, 1, 1)});
            chk(m_eol[2] == 0 && m_eol[6] == 1, "R7 eol after short row", {m_eol[2], m_eol[6]}, 1);
            chk(m_addr[6] == 6, "R6 addr linear across rows", m_addr[6], 6);
        end
    endtask

    // R4, R9: bytes without href and rows outside the frame are ignored.
    task automatic t_gating();
        clear_mon();
        @(negedge clk);
        vs_set(1);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            data = 8'(c * 37);
        end
        send_row(0, 8, 8'hA0);
        vs_set(0);
        idle(4);
        send_row(1, 8, 8'hA0);
        chk(m_n == 4, "R4 only strobed bytes form pixels", m_n, 4);
        chk(m_done == 1, "R9 single done", m_done, 1);
        if (m_n >= 1)
            chk(m_data[0] == {bval(8'hA0, 0, 0), bval(8'hA0, 0, 1)}, "R4 first word", m_data[0], 0);
    endtask

    // R11: arm mid-frame abandons it; next frame restarts at 0.
    task automatic t_arm();
        clear_mon();
        @(negedge clk);
        vs_set(1);
        idle(2);
        send_row(0, 8, 8'hC0);
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        send_row(1, 8, 8'hC0);
        vs_set(0);
        idle(4);
        chk(m_n == 4, "R11 rows after arm ignored", m_n, 4);
        chk(m_done == 0, "R11 no done for abandoned frame", m_done, 0);
        clear_mon();
        run_frame(2, 8, 8'h33);
        check_frame(2, 8, 8'h33, "after arm R11");
    endtask

    // R10: active-low vertical sync.
    task automatic t_polarity();
        @(negedge clk);
        pol = 1'b0;
        vsync = 1'b1;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        idle(2);
        clear_mon();
        send_row(0, 8, 8'h55);
        chk(m_n == 0, "R10 high level inactive when pol=0", m_n, 0);
        run_frame(3, 8, 8'h55);
        check_frame(3, 8, 8'h55, "R10 active-low");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_midframe();
        t_basic();
        t_odd_row();
        t_gating();
        t_arm();
        t_polarity();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule